// File: doc/BRIEF.md
# Push-Button Stream Selector

This block turns a raw mechanical push-button into a choice among four sample streams. The button is first brought into the clock domain by a two-flop synchronizer. It then goes through a debounce filter. A static enable input decides whether the filter is used or bypassed. A rising-edge detector turns each low-to-high transition of the chosen level into a one-clock pulse. Each pulse moves a 2-bit selection one step forward: 0, 1, 2, 3, and then back to 0.

The selection is shown on two active-low indicator outputs. It also drives a registered 4:1 multiplexer over four signed sample streams. A second push-button, the clear button, goes through the same synchronizer and forces the selection back to 0. When the filter is bypassed, contact bounce reaches the edge detector unfiltered, and every bounce counts as a press. This is the behaviour the bypass exists to expose.

Top module: `btn_step_selector`

## Requirements
- R1: While `rst_ni` is low and right after it is released, `sel_o` is 0, `ind_n_o` is 2'b11 and `samp_o` is 0.
- R2: Each low-to-high transition of the chosen button level advances `sel_o` by exactly one. Holding the button high, or releasing it, causes no further change.
- R3: `sel_o` steps through 0, 1, 2, 3 and then wraps from 3 back to 0.
- R4: With `filt_en_i` low, every bounce of `step_btn_i` that is high for at least one cycle, separated by at least one low cycle, advances `sel_o` once.
- R5: With `filt_en_i` high, a high level shorter than `DEB_CYCLES` consecutive cycles does not advance `sel_o`. A low cycle restarts the count.
- R6: With `filt_en_i` high, a press held high for `DEB_CYCLES` cycles advances `sel_o` exactly once. This holds even when bounce precedes the press. `sel_o` changes on the (DEB_CYCLES+3)th rising clock edge after the final rise, and the release does not advance it.
- R7: A high `clear_btn_i` sets `sel_o` to 0 on the third rising edge after it rises. It overrides a step pulse in the same cycle, and that pulse is lost.
- R8: `ind_n_o[i]` is always the inverse of `sel_o[i]`.
- R9: `samp_o` equals `samp0_i`, `samp1_i`, `samp2_i` or `samp3_i` when the selection of the previous cycle was 0, 1, 2 or 3 respectively, each sampled on the same edge.
- R10: With `filt_en_i` low, `sel_o` changes on the third rising edge after `step_btn_i` rises (two synchronizer flops plus the selection register), and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| step_btn_i | input | 1 | Raw step push-button, high when pressed |
| clear_btn_i | input | 1 | Raw clear push-button, high when pressed |
| filt_en_i | input | 1 | Static debounce enable: 1 filters, 0 bypasses |
| samp0_i | input | SAMP_W | Signed sample stream 0 |
| samp1_i | input | SAMP_W | Signed sample stream 1 |
| samp2_i | input | SAMP_W | Signed sample stream 2 |
| samp3_i | input | SAMP_W | Signed sample stream 3 |
| sel_o | output | 2 | Current selection |
| ind_n_o | output | 2 | Active-low indicator copy of the selection |
| samp_o | output | SAMP_W | Registered selected sample |

## Verification
With the filter bypassed, a button rise reaches `sel_o` on the third clock edge: two synchronizer flops, then the selection register. With the filter on, it arrives on edge DEB_CYCLES+3. `samp_o` lags the selection by one more edge, and a clear takes three edges. Inputs are driven on falling edges and outputs are sampled on falling edges. The directed tasks check that `sel_o` has not moved one edge before the due edge, and that it has moved on the due edge. Filter tests that must leave `sel_o` unchanged wait more than twice the debounce window before they compare.

// File: rtl/bss_pkg.sv
package bss_pkg;
    typedef logic [1:0] sel_t;
    localparam sel_t SEL_FIRST = 2'd0;
    localparam int   NUM_SRC   = 4;
endpackage

// File: rtl/bss_sync.sv
module bss_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stg_d[s] = stg_q[s-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) stg_q[g] <= '0;
                else         stg_q[g] <= stg_d[g];
            end
        end
    endgenerate

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/bss_debounce.sv
module bss_debounce #(
    parameter int CYC = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic lvl_i,
    output logic stable_o
);
    localparam int CW = $clog2(CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(CYC - 1);

    typedef struct packed {
        logic          stab;
        logic [CW-1:0] cnt;
    } deb_st_t;

    deb_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (lvl_i != st_q.stab) begin
            if (st_q.cnt == LAST) begin
                st_d.stab = lvl_i;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign stable_o = st_q.stab;
endmodule

// File: rtl/bss_edge.sv
module bss_edge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic lvl_i,
    output logic pulse_o
);
    logic prev_d, prev_q;

    always_comb prev_d = lvl_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= 1'b0;
        else         prev_q <= prev_d;
    end

    assign pulse_o = lvl_i & ~prev_q;
endmodule

// File: rtl/btn_step_selector.sv
module btn_step_selector
    import bss_pkg::*;
#(
    parameter int SAMP_W     = 20,
    parameter int DEB_CYCLES = 16,
    parameter int SYNC_STG   = 2
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     step_btn_i,
    input  logic                     clear_btn_i,
    input  logic                     filt_en_i,
    input  logic signed [SAMP_W-1:0] samp0_i,
    input  logic signed [SAMP_W-1:0] samp1_i,
    input  logic signed [SAMP_W-1:0] samp2_i,
    input  logic signed [SAMP_W-1:0] samp3_i,
    output logic [1:0]               sel_o,
    output logic [1:0]               ind_n_o,
    output logic signed [SAMP_W-1:0] samp_o
);
    typedef struct packed {
        sel_t                     sel;
        logic signed [SAMP_W-1:0] samp;
    } sel_st_t;

    logic [1:0] btn_sync;
    logic       step_sync, clear_sync;
    logic       step_filt, step_lvl, step_pulse;
    logic signed [SAMP_W-1:0] src [NUM_SRC];
    sel_st_t    st_d, st_q;

    bss_sync #(.W(2), .STAGES(SYNC_STG)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i ({clear_btn_i, step_btn_i}),
        .sync_o  (btn_sync)
    );

    assign step_sync  = btn_sync[0];
    assign clear_sync = btn_sync[1];

    bss_debounce #(.CYC(DEB_CYCLES)) u_deb (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .lvl_i    (step_sync),
        .stable_o (step_filt)
    );

    assign step_lvl = filt_en_i ? step_filt : step_sync;

    bss_edge u_edge (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .lvl_i   (step_lvl),
        .pulse_o (step_pulse)
    );

    assign src[0] = samp0_i;
    assign src[1] = samp1_i;
    assign src[2] = samp2_i;
    assign src[3] = samp3_i;

    always_comb begin
        st_d      = st_q;
        st_d.samp = src[st_q.sel];
        if (clear_sync)      st_d.sel = SEL_FIRST;
        else if (step_pulse) st_d.sel = st_q.sel + 2'd1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign sel_o   = st_q.sel;
    assign ind_n_o = ~st_q.sel;
    assign samp_o  = st_q.samp;
endmodule

// File: rtl/bss_checker.sv
module bss_checker #(
    parameter int W = 20
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                clear_btn_i,
    input logic signed [W-1:0] samp0_i,
    input logic signed [W-1:0] samp1_i,
    input logic signed [W-1:0] samp2_i,
    input logic signed [W-1:0] samp3_i,
    input logic [1:0]          sel_o,
    input logic [1:0]          ind_n_o,
    input logic signed [W-1:0] samp_o
);
    function automatic logic signed [W-1:0] pick(input logic [1:0] s,
        input logic signed [W-1:0] a, input logic signed [W-1:0] b,
        input logic signed [W-1:0] c, input logic signed [W-1:0] d);
        case (s)
            2'd0:    return a;
            2'd1:    return b;
            2'd2:    return c;
            default: return d;
        endcase
    endfunction

    AST_IND_INVERTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ind_n_o == ~sel_o); // R8

    AST_STEP_BY_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && sel_o != $past(sel_o)) |->
            (sel_o == $past(sel_o) + 2'd1 || sel_o == 2'd0)); // R3

    AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni, 3) && $past(clear_btn_i, 3)) |-> sel_o == 2'd0); // R7

    AST_MUX_PICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> samp_o == pick($past(sel_o), $past(samp0_i),
            $past(samp1_i), $past(samp2_i), $past(samp3_i))); // R9
endmodule

bind btn_step_selector bss_checker #(.W(SAMP_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_btn_i (clear_btn_i),
    .samp0_i     (samp0_i),
    .samp1_i     (samp1_i),
    .samp2_i     (samp2_i),
    .samp3_i     (samp3_i),
    .sel_o       (sel_o),
    .ind_n_o     (ind_n_o),
    .samp_o      (samp_o)
);

// File: tb/btn_step_selector_test.sv
module btn_step_selector_test;
    localparam int W = 20;
    localparam int N = 16;

    logic clk = 1'b0;
    logic rst_ni = 1'b0;
    logic step_btn = 1'b0, clear_btn = 1'b0, filt_en = 1'b0;
    logic signed [W-1:0] s0, s1, s2, s3;
    logic [1:0] sel_o, ind_n_o;
    logic signed [W-1:0] samp_o;

    int nchk = 0, nbad = 0;
    logic [1:0] exp_sel = 2'd0;

    always #5 clk = ~clk;

    btn_step_selector #(.SAMP_W(W), .DEB_CYCLES(N), .SYNC_STG(2)) uut (
        .clk_i(clk), .rst_ni(rst_ni), .step_btn_i(step_btn),
        .clear_btn_i(clear_btn), .filt_en_i(filt_en),
        .samp0_i(s0), .samp1_i(s1), .samp2_i(s2), .samp3_i(s3),
        .sel_o(sel_o), .ind_n_o(ind_n_o), .samp_o(samp_o)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint exp_samp(input logic [1:0] s);
        case (s)
            2'd0: return longint'(s0);
            2'd1: return longint'(s1);
            2'd2: return longint'(s2);
            default: return longint'(s3);
        endcase
    endfunction

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk_sel(input string req);
        check(sel_o == exp_sel, req, sel_o, exp_sel);
        check(ind_n_o == ~exp_sel, "R8", ind_n_o, ~exp_sel);
    endtask

    task automatic t_reset;
        wait_n(2);
        check(sel_o == 2'd0 && ind_n_o == 2'b11, "R1 sel/ind in reset", {ind_n_o, sel_o}, 4'b1100);
        check(samp_o == 0, "R1 samp in reset", samp_o, 0);
        rst_ni = 1'b1;
        wait_n(1);
        check(sel_o == 2'd0, "R1 after release", sel_o, 0);
        wait_n(1);
        check(samp_o == s0, "R9 after release", samp_o, s0);
    endtask

    // bypass press: exact latency, hold and release do not step
    task automatic t_bypass_press;
        step_btn = 1'b1;
        wait_n(2);
        chk_sel("R10 not before third edge");
        wait_n(1);
        exp_sel = exp_sel + 2'd1;
        chk_sel("R10 on third edge");
        wait_n(1);
        check(samp_o == exp_samp(exp_sel), "R9 follows selection", samp_o, exp_samp(exp_sel));
        wait_n(5);
        chk_sel("R2 hold no step");
        step_btn = 1'b0;
        wait_n(6);
        chk_sel("R2 release no step");
    endtask

    task automatic t_wrap;
        for (int k = 0; k < 4; k++) begin
            step_btn = 1'b1;
            wait_n(3);
            exp_sel = exp_sel + 2'd1;
            chk_sel("R3 step sequence");
            step_btn = 1'b0;
            wait_n(3);
        end
    endtask

    task automatic t_samples;
        s0 = 20'sd1000; s1 = -20'sd2000; s2 = 20'sd3000; s3 = -20'sd4;
        wait_n(1);
        check(samp_o == exp_samp(exp_sel), "R9 new values", samp_o, exp_samp(exp_sel));
        case (exp_sel)
            2'd0: s0 = -20'sd77;
            2'd1: s1 = -20'sd77;
            2'd2: s2 = -20'sd77;
            default: s3 = -20'sd77;
        endcase
        wait_n(1);
        check(samp_o == -77, "R9 tracks live stream", samp_o, -77);
    endtask

    task automatic t_bounce_bypass;
        for (int b = 0; b < 3; b++) begin
            step_btn = 1'b1; wait_n(1);
            step_btn = 1'b0; wait_n(1);
        end
        wait_n(6);
        exp_sel = exp_sel + 2'd3;
        chk_sel("R4 bounce counted");
    endtask

    task automatic t_glitch_filtered;
        step_btn = 1'b1; wait_n(N - 1);
        step_btn = 1'b0; wait_n(1);
        step_btn = 1'b1; wait_n(N - 1);
        step_btn = 1'b0;
        wait_n(2 * N + 4);
        chk_sel("R5 short highs ignored");
    endtask

    task automatic t_filtered_press;
        for (int b = 0; b < 3; b++) begin
            step_btn = 1'b1; wait_n(1);
            step_btn = 1'b0; wait_n(1);
        end
        step_btn = 1'b1;
        wait_n(N + 2);
        chk_sel("R6 not before window");
        wait_n(1);
        exp_sel = exp_sel + 2'd1;
        chk_sel("R6 one step after window");
        wait_n(N + 4);
        chk_sel("R6 held no further step");
        step_btn = 1'b0;
        wait_n(2 * N + 4);
        chk_sel("R6 release filtered");
    endtask

    task automatic t_clear;
        clear_btn = 1'b1;
        wait_n(2);
        chk_sel("R7 not before third edge");
        wait_n(1);
        exp_sel = 2'd0;
        chk_sel("R7 clear on third edge");
        clear_btn = 1'b0;
        wait_n(3);
    endtask

    task automatic t_clear_priority;
        clear_btn = 1'b1;
        step_btn  = 1'b1;
        wait_n(N + 8);
        exp_sel = 2'd0;
        chk_sel("R7 clear beats step");
        clear_btn = 1'b0;
        wait_n(N + 4);
        step_btn = 1'b0;
        wait_n(2 * N + 4);
        chk_sel("R7 swallowed step stays lost");
    endtask

    initial begin
        s0 = 20'sd11; s1 = -20'sd22; s2 = 20'sd33; s3 = -20'sd44;
        t_reset();
        t_bypass_press();
        t_wrap();
        t_samples();
        t_bounce_bypass();
        wait_n(4);
        filt_en = 1'b1;
        wait_n(N + 4);
        chk_sel("R5 enabling filter no step");
        t_glitch_filtered();
        t_filtered_press();
        t_clear();
        step_btn = 1'b1; wait_n(N + 4); step_btn = 1'b0; wait_n(N + 4);
        exp_sel = exp_sel + 2'd1;
        chk_sel("R6 step before priority test");
        t_clear_priority();
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nbad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule